// File: doc/BRIEF.md
# Soft-Reset and Clock-Gate Sequencer

This block gives a peripheral a reset and a clock gate that software controls through one 32-bit control word. The word has two live bits: a reset request and a gate flag. Software can write the word directly. It can also set bits by writing a mask to a set-alias address, or clear bits by writing a mask to a clear-alias address. Reading the control word at any of its three addresses returns its current value. Reads change nothing, so software can poll the word freely while it waits.

When the reset request goes high, the protected logic is held at its reset values. A fixed number of cycles later the sequencer raises the gate flag by itself. Software polls for that flag as the sign that the reset has taken hold. To bring the peripheral back, software clears the reset bit and waits for it to read as zero. It then clears the gate bit, and a zero there means the clock is running again.

The gate is modelled as a clock-enable output. A small bank of word registers behind the same bus stands in for the protected logic. That bank shows the effect of both controls directly at the bus.

Top module: `srcg_ctrl`

## Requirements
- R1: After the hardware reset, the control word reads 0x0000_0000, `prot_rst` is 0, `prot_clk_en` is 1 and every bank register reads 0.
- R2: A write to offset 0x00 loads bit 31 (reset request) and bit 30 (gate flag) from the write data. All other bits of the control word always read 0.
- R3: A write to offset 0x04 ORs write-data bits 31 and 30 into the control word, and a write to offset 0x08 clears the bits set in the mask. A mask with both of those bits at zero leaves the word unchanged.
- R4: Reads at offsets 0x00, 0x04 and 0x08 all return the control word, and a read never alters it.
- R5: `prot_rst` is 1 exactly while the reset bit reads 1. It changes on the clock edge that captures the write.
- R6: The gate flag sets by itself on the 4th clock edge after the edge that set the reset bit, provided the reset bit stays set for that whole time. This happens only once for each assertion of the reset bit. If the reset bit is cleared before the 4th edge, the gate flag does not set.
- R7: `prot_clk_en` is the inverse of the gate flag as it reads back.
- R8: While the reset bit is set, every bank register is cleared and reads 0 from the next cycle on.
- R9: While the gate flag is set, writes to bank registers are ignored. Accesses to the control word still work.
- R10: While running, bank register i at offset 0x10 + 4*i is written and read back as a full word. A read at an unmapped or misaligned offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| bus_wr | input | 1 | Write strobe, captured on the rising edge |
| bus_rd | input | 1 | Read strobe, gates the read data |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| prot_rst | output | 1 | Reset to the protected logic |
| prot_clk_en | output | 1 | Clock enable to the protected logic |

## Verification
Every write takes effect on the rising edge that captures it. Read data is combinational, so the bench drives each access on a falling edge and samples the result a moment later. A read that follows a write therefore shows the new value. The self-set gate flag is due on the 4th rising edge after the capturing edge. The bench reads the control word on each falling edge after the write, expects 0 in bit 30 on the first three reads and 1 on the fourth, and keeps reading afterwards to show that the flag sets only once. The case where the reset is withdrawn early issues its clearing write so that it is captured on the 3rd edge, one edge before the self-set would happen.

// File: rtl/srcg_pkg.sv
package srcg_pkg;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned RST_BIT  = 31;
  localparam int unsigned GATE_BIT = 30;
  localparam int unsigned OFS_BASE = 0;
  localparam int unsigned OFS_SET  = 4;
  localparam int unsigned OFS_CLR  = 8;
  localparam int unsigned OFS_BANK = 16;

  typedef enum logic [1:0] {
    CTL_ALIAS_BASE = 2'd0,
    CTL_ALIAS_SET  = 2'd1,
    CTL_ALIAS_CLR  = 2'd2
  } ctl_alias_e;

  // Two live bits: [1] reset request, [0] gate flag
  typedef struct packed {
    logic srst;
    logic gate;
  } ctl_bits_t;

  function automatic ctl_bits_t apply_alias(ctl_bits_t cur, ctl_bits_t mask,
                                            ctl_alias_e kind);
    ctl_bits_t r;
    case (kind)
      CTL_ALIAS_SET: r = cur | mask;
      CTL_ALIAS_CLR: r = cur & ~mask;
      default:       r = mask;
    endcase
    return r;
  endfunction

  function automatic ctl_bits_t mask_from_word(logic [DATA_W-1:0] w);
    ctl_bits_t m;
    m.srst = w[RST_BIT];
    m.gate = w[GATE_BIT];
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] word_from_bits(ctl_bits_t b);
    logic [DATA_W-1:0] w;
    w = '0;
    w[RST_BIT]  = b.srst;
    w[GATE_BIT] = b.gate;
    return w;
  endfunction

endpackage

// File: rtl/srcg_decode.sv
module srcg_decode
  import srcg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_BANK = 4,
  localparam int unsigned IDX_W   = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              ctrl_wr,
  output logic              ctrl_rd,
  output ctl_alias_e        ctrl_alias,
  output logic              bank_wr,
  output logic              bank_rd,
  output logic [IDX_W-1:0]  bank_idx
);

  localparam logic [ADDR_W-1:0] A_BASE  = ADDR_W'(OFS_BASE);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_BANK  = ADDR_W'(OFS_BANK);
  localparam logic [ADDR_W-1:0] A_SPAN  = ADDR_W'(4 * NUM_BANK);

  logic [ADDR_W-1:0] rel;
  logic              ctrl_hit;
  logic              bank_hit;

  always_comb begin
    rel        = bus_addr - A_BANK;
    ctrl_alias = CTL_ALIAS_BASE;
    ctrl_hit   = 1'b0;
    if (bus_addr == A_BASE) begin
      ctrl_hit = 1'b1;
    end else if (bus_addr == A_SET) begin
      ctrl_hit   = 1'b1;
      ctrl_alias = CTL_ALIAS_SET;
    end else if (bus_addr == A_CLR) begin
      ctrl_hit   = 1'b1;
      ctrl_alias = CTL_ALIAS_CLR;
    end
    bank_hit = (bus_addr >= A_BANK) && (rel < A_SPAN) && (bus_addr[1:0] == 2'b00);
    bank_idx = rel[IDX_W+1:2];
  end

  assign ctrl_wr = bus_wr && ctrl_hit;
  assign ctrl_rd = bus_rd && ctrl_hit;
  assign bank_wr = bus_wr && bank_hit;
  assign bank_rd = bus_rd && bank_hit;

endmodule

// File: rtl/srcg_seq.sv
module srcg_seq
  import srcg_pkg::*;
#(
  parameter int unsigned GATE_DELAY = 4,
  localparam int unsigned CNT_W     = $clog2(GATE_DELAY + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  ctl_alias_e ctrl_alias,
  input  ctl_bits_t  wmask,
  output ctl_bits_t  ctrl_q,
  output logic       auto_evt
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(GATE_DELAY - 1);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(GATE_DELAY);

  logic [CNT_W-1:0] hold_cnt;
  ctl_bits_t        ctrl_d;

  // Fires once per reset assertion, on the edge that ends the hold window
  assign auto_evt = ctrl_q.srst && (hold_cnt == LAST);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = apply_alias(ctrl_q, wmask, ctrl_alias);
    if (auto_evt) ctrl_d.gate = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      hold_cnt <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (!ctrl_q.srst)        hold_cnt <= '0;
      else if (hold_cnt != SAT) hold_cnt <= hold_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/srcg_bank.sv
module srcg_bank
  import srcg_pkg::*;
#(
  parameter int unsigned NUM_BANK = 4,
  localparam int unsigned IDX_W   = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         clk_en,
  input  logic                         wr,
  input  logic [IDX_W-1:0]             idx,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rd_word,
  output logic [NUM_BANK*DATA_W-1:0]   flat_q,
  output logic                         all_zero
);

  logic [DATA_W-1:0] word_q [NUM_BANK];

  for (genvar g = 0; g < NUM_BANK; g++) begin : g_word
    logic sel;
    assign sel = wr && clk_en && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[g] <= '0;
      else if (clr) word_q[g] <= '0;
      else if (sel) word_q[g] <= wdata;
    end
    assign flat_q[g*DATA_W +: DATA_W] = word_q[g];
  end

  assign rd_word  = word_q[idx];
  assign all_zero = (flat_q == '0);

endmodule

// File: rtl/srcg_ctrl.sv
module srcg_ctrl
  import srcg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned NUM_BANK   = 4,
  parameter int unsigned GATE_DELAY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              prot_rst,
  output logic              prot_clk_en
);

  localparam int unsigned IDX_W  = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;
  localparam int unsigned FLAT_W = NUM_BANK * DATA_W;

  logic               ctrl_wr;
  logic               ctrl_rd;
  ctl_alias_e         ctrl_alias;
  logic               bank_wr;
  logic               bank_rd;
  logic [IDX_W-1:0]   bank_idx;
  ctl_bits_t          wmask;
  ctl_bits_t          ctrl_q;
  logic               auto_evt;
  logic [DATA_W-1:0]  bank_word;
  logic [FLAT_W-1:0]  bank_flat;
  logic               bank_all_zero;

  assign wmask = mask_from_word(bus_wdata);

  srcg_decode #(.ADDR_W(ADDR_W), .NUM_BANK(NUM_BANK)) i_decode (
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .ctrl_wr    (ctrl_wr),
    .ctrl_rd    (ctrl_rd),
    .ctrl_alias (ctrl_alias),
    .bank_wr    (bank_wr),
    .bank_rd    (bank_rd),
    .bank_idx   (bank_idx)
  );

  srcg_seq #(.GATE_DELAY(GATE_DELAY)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_alias (ctrl_alias),
    .wmask      (wmask),
    .ctrl_q     (ctrl_q),
    .auto_evt   (auto_evt)
  );

  assign prot_rst    = ctrl_q.srst;
  assign prot_clk_en = ~ctrl_q.gate;

  srcg_bank #(.NUM_BANK(NUM_BANK)) i_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (prot_rst),
    .clk_en   (prot_clk_en),
    .wr       (bank_wr),
    .idx      (bank_idx),
    .wdata    (bus_wdata),
    .rd_word  (bank_word),
    .flat_q   (bank_flat),
    .all_zero (bank_all_zero)
  );

  always_comb begin
    if (ctrl_rd)      bus_rdata = word_from_bits(ctrl_q);
    else if (bank_rd) bus_rdata = bank_word;
    else              bus_rdata = '0;
  end

endmodule

// File: rtl/srcg_chk.sv
module srcg_chk
  import srcg_pkg::*;
#(
  parameter int unsigned GATE_DELAY = 4,
  parameter int unsigned FLAT_W     = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prot_rst,
  input logic              prot_clk_en,
  input logic              ctrl_wr,
  input ctl_alias_e        ctrl_alias,
  input ctl_bits_t         wmask,
  input ctl_bits_t         ctrl_q,
  input logic              auto_evt,
  input logic              bank_wr,
  input logic [FLAT_W-1:0] bank_flat,
  input logic              bank_all_zero
);

  localparam int unsigned CW = $clog2(GATE_DELAY + 2);

  // Independent count of consecutive cycles with the reset output high
  logic [CW-1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          run_cnt <= '0;
    else if (!prot_rst)                  run_cnt <= '0;
    else if (run_cnt != CW'(GATE_DELAY)) run_cnt <= run_cnt + 1'b1;
  end

  assert_set_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_alias == CTL_ALIAS_SET && wmask.srst) |=> prot_rst);

  assert_zero_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_alias != CTL_ALIAS_BASE && wmask == '0 && !auto_evt)
      |=> $stable(ctrl_q));

  assert_auto_timing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    auto_evt |-> (prot_rst && run_cnt == CW'(GATE_DELAY - 1)));

  assert_gate_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(prot_clk_en) && !$past(ctrl_wr)) |-> $past(auto_evt));

  assert_bank_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(prot_rst) |-> bank_all_zero);

  assert_gated_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr && !prot_clk_en && !prot_rst) |=> $stable(bank_flat));

endmodule

bind srcg_ctrl srcg_chk #(.GATE_DELAY(GATE_DELAY), .FLAT_W(FLAT_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .prot_rst      (prot_rst),
  .prot_clk_en   (prot_clk_en),
  .ctrl_wr       (ctrl_wr),
  .ctrl_alias    (ctrl_alias),
  .wmask         (wmask),
  .ctrl_q        (ctrl_q),
  .auto_evt      (auto_evt),
  .bank_wr       (bank_wr),
  .bank_flat     (bank_flat),
  .bank_all_zero (bank_all_zero)
);

// File: tb/test_srcg_ctrl.sv
module test_srcg_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        prot_rst;
  logic        prot_clk_en;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srcg_ctrl i_srcg_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .prot_rst    (prot_rst),
    .prot_clk_en (prot_clk_en)
  );

  localparam logic [7:0] O_BASE = 8'h00;
  localparam logic [7:0] O_SET  = 8'h04;
  localparam logic [7:0] O_CLR  = 8'h08;
  localparam logic [31:0] B_RST  = 32'h8000_0000;
  localparam logic [31:0] B_GATE = 32'h4000_0000;

  // {offset, write data, expected control word afterwards}
  localparam logic [71:0] VEC [0:7] = '{
    {8'h00, 32'h7FFF_FFFF, 32'h4000_0000},
    {8'h08, 32'h4000_0000, 32'h0000_0000},
    {8'h04, 32'h0000_0000, 32'h0000_0000},
    {8'h04, 32'h4000_0001, 32'h4000_0000},
    {8'h04, 32'h0000_0000, 32'h4000_0000},
    {8'h08, 32'h0000_0000, 32'h4000_0000},
    {8'h08, 32'h0000_FFFF, 32'h4000_0000},
    {8'h00, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  // Drives a read on the next falling edge and samples shortly after
  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(O_BASE, rd);       check("R1 control word", rd, 32'h0);
    check("R1 prot_rst", {31'd0, prot_rst}, 32'd0);
    check("R1 prot_clk_en", {31'd0, prot_clk_en}, 32'd1);
    bus_read(8'h10, rd);        check("R1 bank0", rd, 32'h0);

    // R2 R3 R7 table walk
    foreach (VEC[i]) begin
      bus_write(VEC[i][71:64], VEC[i][63:32]);
      bus_read(O_BASE, rd);
      check($sformatf("R2/R3 vector %0d", i), rd, VEC[i][31:0]);
      check($sformatf("R7 vector %0d", i), {31'd0, prot_clk_en}, {31'd0, ~VEC[i][30]});
    end

    // R4 reads at every alias return the word and change nothing
    bus_write(O_SET, B_GATE);
    bus_read(O_SET, rd);        check("R4 read at set alias", rd, B_GATE);
    bus_read(O_CLR, rd);        check("R4 read at clear alias", rd, B_GATE);
    bus_read(O_BASE, rd);       check("R4 word after alias reads", rd, B_GATE);
    bus_write(O_CLR, B_GATE);

    // R10 bank access while running
    bus_write(8'h10, 32'hA5A5_0001);
    bus_write(8'h1C, 32'h0000_BEEF);
    bus_read(8'h10, rd);        check("R10 bank0", rd, 32'hA5A5_0001);
    bus_read(8'h1C, rd);        check("R10 bank3", rd, 32'h0000_BEEF);
    bus_read(8'h0C, rd);        check("R10 unmapped", rd, 32'h0);
    bus_read(8'h11, rd);        check("R10 misaligned", rd, 32'h0);

    // R9 gated writes ignored, control word still reachable
    bus_write(O_SET, B_GATE);
    check("R9 clk_en low", {31'd0, prot_clk_en}, 32'd0);
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_read(8'h10, rd);        check("R9 bank0 kept", rd, 32'hA5A5_0001);
    bus_read(O_BASE, rd);       check("R9 control readable", rd, B_GATE);
    bus_write(O_CLR, B_GATE);
    bus_write(8'h10, 32'h1234_5678);
    bus_read(8'h10, rd);        check("R9 write after ungate", rd, 32'h1234_5678);

    // R5 R6 R8 full reset then self-set gate
    bus_write(O_SET, B_RST);
    check("R5 prot_rst high", {31'd0, prot_rst}, 32'd1);
    for (int k = 1; k <= 3; k++) begin
      bus_read(O_BASE, rd);
      check($sformatf("R6 before delay, read %0d", k), rd, B_RST);
    end
    bus_read(O_BASE, rd);       check("R6 gate self-set on 4th edge", rd, B_RST | B_GATE);
    check("R7 clk_en after self-set", {31'd0, prot_clk_en}, 32'd0);
    bus_read(8'h10, rd);        check("R8 bank0 cleared", rd, 32'h0);
    bus_read(8'h1C, rd);        check("R8 bank3 cleared", rd, 32'h0);
    for (int k = 0; k < 10; k++) bus_read(O_BASE, rd);
    check("R6 word steady while held", rd, B_RST | B_GATE);

    // Release in order: reset bit, then gate bit
    bus_write(O_CLR, B_RST);
    bus_read(O_BASE, rd);       check("R5 reset released", rd, B_GATE);
    check("R5 prot_rst low", {31'd0, prot_rst}, 32'd0);
    check("R7 still gated", {31'd0, prot_clk_en}, 32'd0);
    bus_write(O_CLR, B_GATE);
    bus_read(O_BASE, rd);       check("R7 running word", rd, 32'h0);
    check("R7 clk_en restored", {31'd0, prot_clk_en}, 32'd1);

    // R6 early withdrawal: the clearing write lands on the 3rd edge
    bus_write(O_SET, B_RST);
    bus_read(O_BASE, rd);       check("R6 early: reset set", rd, B_RST);
    bus_write(O_CLR, B_RST);
    for (int k = 0; k < 8; k++) bus_read(O_BASE, rd);
    check("R6 early withdrawal leaves gate clear", rd, 32'h0);
    check("R6 clk_en after early withdrawal", {31'd0, prot_clk_en}, 32'd1);

    @(negedge clk);
    bus_rd = 1'b0;
    summary();
    $finish;
  end

endmodule